// File: doc/BRIEF.md
# Default Virtual Address Segment Decoder

This block sorts each virtual address from a load/store or fetch unit into one of the default address-space segments. It works in a 32-bit mode and a 64-bit mode, chosen for each request. A direct-mapped segment yields its physical address and cache attribute at once. A page-mapped segment is flagged so that the request goes on to a TLB path. The requester's privilege level is checked against the segment in the same pass.

Each request is a valid-qualified address with a 2-bit privilege level and a mode bit. Privilege 0 is the most privileged level and 3 is user mode. One cycle later the block returns a registered result: the physical address, the cache attribute, a page-mapped flag and an access-fault flag. In 64-bit mode the cache attribute is taken from address bits inside the direct segment, so translation, attribute choice and the privilege check all come from one decode.

Top module: `vaseg_decoder`

## Requirements
- R1: When `inValid` is high at a clock edge, `outValid` is high for the cycle after that edge. Otherwise `outValid` is low. After reset every output is zero.
- R2: In 32-bit mode (`inWide`=0), an address with bit 31 clear is page-mapped for every privilege level. The result is `outPaged`=1, `outAttr`=1, `outPhys`=0 and no fault.
- R3: In 32-bit mode, bits 31:30 = 10 select a direct segment. `outPhys` is the low 32 address bits with bits 31:30 cleared, and its upper half is zero. `outAttr` is 0 (uncached) when bit 29 is 0 and 1 (cached) when bit 29 is 1.
- R4: In 32-bit mode, bits 31:30 = 11 select a page-mapped kernel segment. The result is `outPaged`=1 and `outAttr`=1, for privilege 0 only.
- R5: In 32-bit mode, address bits 63:32 have no effect on any output.
- R6: In 64-bit mode, address bits 63:62 = 00 select a page-mapped segment open to all levels. Bits 63:62 = 11 select a page-mapped segment for privilege 0 only. Both give `outPaged`=1, `outAttr`=1 and `outPhys`=0.
- R7: In 64-bit mode, bits 63:62 = 10 select a direct segment. `outPhys` is the address with bits 63:60 cleared, and `outAttr` equals address bits 61:60: 0 is strongly-ordered uncached, 1 is coherent cached and 2 is weakly-ordered uncached.
- R8: In a 64-bit direct segment, address bits 61:60 = 3 raise a fault.
- R9: In 64-bit mode, bits 63:62 = 01 raise a fault when parameter `OpenSeg01` is 0. When it is 1, that segment decodes as a direct segment in the same way as R7 and R8.
- R10: A privilege level other than 0 faults on every segment except the low user segment (32-bit bit 31 = 0, or 64-bit bits 63:62 = 00).
- R11: A faulting result has `outFault`=1, `outPhys`=0, `outAttr`=0 and `outPaged`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request qualifier |
| inWide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| inPriv | input | 2 | Privilege level, 0 most privileged, 3 user |
| inAddr | input | 64 | Virtual address (32-bit mode uses bits 31:0) |
| outValid | output | 1 | Result qualifier, one cycle after the request |
| outPhys | output | 64 | Physical address for direct segments, else zero |
| outAttr | output | 2 | Cache attribute code |
| outPaged | output | 1 | Request must go through the TLB path |
| outFault | output | 1 | Access fault |

## Verification
Addresses are driven at the edges of every segment in both modes: the first and last words of each 32-bit range, and each top-bit pattern in 64-bit mode. These show whether the decoder looks at the right boundary bits and clears the right upper bits. The same addresses are then repeated at privilege 0, at an intermediate level and at user level. This separates the privilege check from the segment decode. All four attribute codes are driven into both 64-bit direct segments, against two instances with the reserved segment closed and open. This exposes attribute pass-through, the undefined-code fault and the parameter switch. Junk in the upper half of 32-bit requests, and back-to-back requests mixed with idle cycles, check that nothing leaks from the ignored bits and that results keep their one-cycle timing.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;
  localparam int VA_W     = 64;
  localparam int NARROW_W = 32;
  localparam int CLR_WIDE = 4;   // upper bits cleared in 64-bit direct segments
  localparam int CLR_NARR = 2;   // upper bits cleared in 32-bit direct segments

  typedef enum logic [1:0] {
    ATTR_SO_UNCACHED = 2'd0,
    ATTR_COHERENT    = 2'd1,
    ATTR_WO_UNCACHED = 2'd2,
    ATTR_UNDEF       = 2'd3
  } attr_e;

  typedef enum logic [1:0] {
    REG_USER_PAGED,
    REG_KERN_PAGED,
    REG_DIRECT,
    REG_BLOCKED
  } region_e;

  typedef struct packed {
    logic       capture;
    logic       paged;
    logic       direct;
    logic       fault;
    logic [1:0] attr;
  } ctl_t;
endpackage

// File: rtl/vaseg_ctrl.sv
module vaseg_ctrl
  import vaseg_pkg::*;
#(
  parameter bit OpenSeg01 = 1'b0
) (
  input  logic       inValid,
  input  logic       inWide,
  input  logic [1:0] inPriv,
  input  logic [3:0] wideTop,    // address bits 63:60
  input  logic [2:0] narrowTop,  // address bits 31:29
  output ctl_t       ctl
);
  logic    seg01Open;
  region_e region;
  logic [1:0] rawAttr;
  logic    privOk;
  logic    attrOk;
  logic    fault;
  logic    isPaged;

  generate
    if (OpenSeg01) begin : g_open
      assign seg01Open = 1'b1;
    end else begin : g_closed
      assign seg01Open = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!inWide) begin
      if (!narrowTop[2])     region = REG_USER_PAGED;
      else if (narrowTop[1]) region = REG_KERN_PAGED;
      else                   region = REG_DIRECT;
      rawAttr = narrowTop[0] ? ATTR_COHERENT : ATTR_SO_UNCACHED;
    end else begin
      unique case (wideTop[3:2])
        2'b00:   region = REG_USER_PAGED;
        2'b11:   region = REG_KERN_PAGED;
        2'b10:   region = REG_DIRECT;
        default: region = seg01Open ? REG_DIRECT : REG_BLOCKED;
      endcase
      rawAttr = wideTop[1:0];
    end
  end

  always_comb begin
    privOk  = (region == REG_USER_PAGED) || (inPriv == 2'd0);
    attrOk  = !((region == REG_DIRECT) && (rawAttr == ATTR_UNDEF));
    fault   = (region == REG_BLOCKED) || !privOk || !attrOk;
    isPaged = (region == REG_USER_PAGED) || (region == REG_KERN_PAGED);

    ctl.capture = inValid;
    ctl.fault   = fault;
    ctl.paged   = !fault && isPaged;
    ctl.direct  = !fault && (region == REG_DIRECT);
    if (fault)        ctl.attr = 2'd0;
    else if (isPaged) ctl.attr = ATTR_COHERENT;
    else              ctl.attr = rawAttr;
  end
endmodule

// File: rtl/vaseg_dpath.sv
module vaseg_dpath
  import vaseg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_t            ctl,
  input  logic            inWide,
  input  logic [VA_W-1:0] inAddr,
  output logic            outValid,
  output logic [VA_W-1:0] outPhys,
  output logic [1:0]      outAttr,
  output logic            outPaged,
  output logic            outFault
);
  localparam logic [VA_W-1:0] MaskWide =
    {{CLR_WIDE{1'b0}}, {(VA_W-CLR_WIDE){1'b1}}};
  localparam logic [VA_W-1:0] MaskNarrow =
    {{(VA_W-NARROW_W+CLR_NARR){1'b0}}, {(NARROW_W-CLR_NARR){1'b1}}};

  logic [VA_W-1:0] directPhys;
  logic [VA_W-1:0] nextPhys;

  always_comb begin
    directPhys = inAddr & (inWide ? MaskWide : MaskNarrow);
    nextPhys   = ctl.direct ? directPhys : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outPhys  <= '0;
      outAttr  <= 2'd0;
      outPaged <= 1'b0;
      outFault <= 1'b0;
    end else begin
      outValid <= ctl.capture;
      if (ctl.capture) begin
        outPhys  <= nextPhys;
        outAttr  <= ctl.attr;
        outPaged <= ctl.paged;
        outFault <= ctl.fault;
      end
    end
  end

  // R11: a fault carries no address, attribute or TLB flag
  a_r11_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    outFault |-> (outPhys == '0 && outAttr == 2'd0 && !outPaged));

  // R7: a direct result never carries the cleared upper bits
  a_r7_direct_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outPaged && !outFault) |-> (outPhys[VA_W-1 -: CLR_WIDE] == '0));
endmodule

// File: rtl/vaseg_decoder.sv
module vaseg_decoder
  import vaseg_pkg::*;
#(
  parameter bit OpenSeg01 = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inValid,
  input  logic            inWide,
  input  logic [1:0]      inPriv,
  input  logic [VA_W-1:0] inAddr,
  output logic            outValid,
  output logic [VA_W-1:0] outPhys,
  output logic [1:0]      outAttr,
  output logic            outPaged,
  output logic            outFault
);
  ctl_t ctl;

  vaseg_ctrl #(.OpenSeg01(OpenSeg01)) u_ctrl (
    .inValid  (inValid),
    .inWide   (inWide),
    .inPriv   (inPriv),
    .wideTop  (inAddr[VA_W-1 -: 4]),
    .narrowTop(inAddr[NARROW_W-1 -: 3]),
    .ctl      (ctl)
  );

  vaseg_dpath u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .inWide  (inWide),
    .inAddr  (inAddr),
    .outValid(outValid),
    .outPhys (outPhys),
    .outAttr (outAttr),
    .outPaged(outPaged),
    .outFault(outFault)
  );

  // R1: result qualifier follows the request by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R2: low user half of 32-bit space never faults
  a_r2_user_low: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !inWide && !inAddr[NARROW_W-1]) |=> (outPaged && !outFault));

  // R10: non-zero privilege outside the user segment faults
  a_r10_priv_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inPriv != 2'd0 &&
     ((!inWide && inAddr[NARROW_W-1]) || (inWide && inAddr[VA_W-1 -: 2] != 2'b00)))
    |=> outFault);
endmodule

// File: tb/vaseg_decoder_bench.sv
`timescale 1ns/1ps
module vaseg_decoder_bench;
  import vaseg_pkg::*;

  typedef struct packed {
    logic [63:0] phys;
    logic [1:0]  attr;
    logic        paged;
    logic        fault;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inWide = 1'b0;
  logic [1:0] inPriv = 2'd0;
  logic [63:0] inAddr = '0;

  logic sValid, sPaged, sFault, oValid, oPaged, oFault;
  logic [63:0] sPhys, oPhys;
  logic [1:0] sAttr, oAttr;

  int nChecks = 0;
  int nFails = 0;
  exp_t qShut[$];
  exp_t qOpen[$];
  string qTag[$];

  always #2 clk = ~clk;

  vaseg_decoder #(.OpenSeg01(1'b0)) u_vaseg_decoder (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inWide(inWide),
    .inPriv(inPriv), .inAddr(inAddr), .outValid(sValid), .outPhys(sPhys),
    .outAttr(sAttr), .outPaged(sPaged), .outFault(sFault));

  vaseg_decoder #(.OpenSeg01(1'b1)) u_open (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inWide(inWide),
    .inPriv(inPriv), .inAddr(inAddr), .outValid(oValid), .outPhys(oPhys),
    .outAttr(oAttr), .outPaged(oPaged), .outFault(oFault));

  function automatic exp_t model(input logic wide, input logic [1:0] priv,
                                 input logic [63:0] a, input bit open01);
    exp_t e;
    logic kern, direct, bad;
    e = '0; kern = 0; direct = 0; bad = 0;
    if (!wide) begin
      if (a[31]) begin
        if (a[30]) kern = 1;
        else begin
          direct = 1;
          e.phys = {34'd0, a[29:0]};
          e.attr = a[29] ? 2'd1 : 2'd0;
        end
      end
    end else begin
      case (a[63:62])
        2'b00: ;
        2'b11: kern = 1;
        2'b10: direct = 1;
        default: begin direct = open01; bad = !open01; end
      endcase
      if (direct) begin
        e.phys = {4'd0, a[59:0]};
        e.attr = a[61:60];
        if (a[61:60] == 2'd3) bad = 1;
      end
    end
    if ((kern || direct || bad) && priv != 2'd0) bad = 1;
    if (!direct) begin e.paged = 1; e.attr = 2'd1; end
    if (bad) e = '{phys: '0, attr: 2'd0, paged: 1'b0, fault: 1'b1};
    return e;
  endfunction

  task automatic send(input logic wide, input logic [1:0] priv,
                      input logic [63:0] a, input string tag);
    @(negedge clk);
    inValid = 1'b1; inWide = wide; inPriv = priv; inAddr = a;
    qShut.push_back(model(wide, priv, a, 1'b0));
    qOpen.push_back(model(wide, priv, a, 1'b1));
    qTag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; inAddr = 64'hFFFF_FFFF_FFFF_FFFF;
    end
  endtask

  task automatic compare(input string who, input string tag, input exp_t act, input exp_t exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual phys=%h attr=%0d paged=%0b fault=%0b expected phys=%h attr=%0d paged=%0b fault=%0b",
               tag, who, act.phys, act.attr, act.paged, act.fault,
               exp.phys, exp.attr, exp.paged, exp.fault);
    end
  endtask

  // monitor: scoreboard pop one cycle after each request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (sValid !== (qTag.size() != 0) || oValid !== sValid) begin
          nChecks++; nFails++;
          $display("FAIL R1 valid timing: actual %0b/%0b expected %0b",
                   sValid, oValid, qTag.size() != 0);
        end
        if (qTag.size() != 0) begin
          string t;
          exp_t es, eo;
          t = qTag.pop_front(); es = qShut.pop_front(); eo = qOpen.pop_front();
          compare("closed", t, '{phys: sPhys, attr: sAttr, paged: sPaged, fault: sFault}, es);
          compare("open", t, '{phys: oPhys, attr: oAttr, paged: oPaged, fault: oFault}, eo);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        nChecks++;
        if (sValid !== 1'b0 || sPhys !== '0 || sAttr !== 2'd0 || sPaged !== 1'b0 || sFault !== 1'b0) begin
          nFails++;
          $display("FAIL R1 reset: actual v=%0b phys=%h attr=%0d expected all zero", sValid, sPhys, sAttr);
        end
        rst_n = 1'b1;
        idle(2);
        // R2 low user half of 32-bit space
        send(0, 2'd3, 64'h0000_0000_0000_1000, "R2 user low p3");
        send(0, 2'd0, 64'h0000_0000_7FFF_FFFF, "R2 user top p0");
        send(0, 2'd2, 64'h0000_0000_0000_0000, "R2 user zero p2");
        idle(1);
        // R3 direct 32-bit
        send(0, 2'd0, 64'h0000_0000_8000_1000, "R3 uncached");
        send(0, 2'd0, 64'h0000_0000_A000_1000, "R3 cached");
        send(0, 2'd0, 64'h0000_0000_9FFF_FFFF, "R3 uncached end");
        send(0, 2'd0, 64'h0000_0000_BFFF_FFFC, "R3 cached end");
        // R4 kernel paged 32-bit
        send(0, 2'd0, 64'h0000_0000_C000_0000, "R4 kpaged start");
        send(0, 2'd0, 64'h0000_0000_FFFF_FFFF, "R4 kpaged end");
        send(0, 2'd3, 64'h0000_0000_C000_0000, "R4 R10 kpaged user");
        idle(2);
        // R5 upper half ignored in 32-bit mode
        send(0, 2'd0, 64'hDEAD_BEEF_8000_1000, "R5 junk direct");
        send(0, 2'd3, 64'hFFFF_FFFF_0000_2000, "R5 junk user");
        send(0, 2'd1, 64'h1234_5678_A000_0040, "R5 R10 junk priv1");
        // R6 64-bit paged
        send(1, 2'd3, 64'h0000_0000_0000_1000, "R6 user p3");
        send(1, 2'd0, 64'h3FFF_FFFF_FFFF_FFFF, "R6 user top");
        send(1, 2'd0, 64'hC000_0000_0000_0000, "R6 kpaged");
        send(1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R6 R10 kpaged p2");
        idle(1);
        // R7 attributes from address bits
        send(1, 2'd0, 64'h8000_0000_0000_1000, "R7 so uncached");
        send(1, 2'd0, 64'h9000_0000_0000_1000, "R7 coherent");
        send(1, 2'd0, 64'hA000_0000_0000_1000, "R7 wo uncached");
        send(1, 2'd0, 64'hAFFF_FFFF_FFFF_FFFF, "R7 wo end");
        // R8 undefined attribute
        send(1, 2'd0, 64'hB000_0000_0000_1000, "R8 undef attr");
        // R9 reserved segment
        send(1, 2'd0, 64'h4000_0000_0000_1000, "R9 seg01 attr0");
        send(1, 2'd0, 64'h5000_0000_0000_0ABC, "R9 seg01 attr1");
        send(1, 2'd0, 64'h6123_4567_89AB_CDEF, "R9 seg01 attr2");
        send(1, 2'd0, 64'h7000_0000_0000_1000, "R9 R8 seg01 attr3");
        // R10 / R11 privilege on direct segments
        send(1, 2'd3, 64'h8000_0000_0000_1000, "R10 R11 direct p3");
        send(1, 2'd1, 64'h5000_0000_0000_1000, "R10 R11 seg01 p1");
        send(0, 2'd3, 64'h0000_0000_8000_1000, "R10 R11 narrow direct p3");
        idle(4);
        nChecks++;
        if (qTag.size() != 0) begin
          nFails++;
          $display("FAIL R1 leftover: actual %0d expected 0", qTag.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule